// File: doc/BRIEF.md
# Root Port Interrupt Status Controller

This block collects interrupt events seen by a root-port bridge and turns them into a single interrupt line for a local processor. Four legacy interrupt assertions (A, B, C and D) and a "completion arrived" event reach it as one-cycle pulses. Each pulse sets a sticky bit in a status register. Software clears a bit by writing 1 to it. A mask register with the same bit layout decides which status bits may drive the interrupt line, and that line is produced by a register.

A third register is read-only. It reports the live, unlatched levels of the local interrupt inputs, zero-extended to 32 bits. All registers sit on a simple word access port. A read returns its data, with a valid strobe, one cycle after the request.

Top module: `rpirq_ctrl`

## Requirements
- R1: After synchronous reset the status and mask registers are zero, `irq_out` is 0, `rd_valid` is 0 and `rd_data` is 0.
- R2: A pulse on `intx_evt[k]` sets status bit k, where bit 0 is A, bit 1 is B, bit 2 is C and bit 3 is D. The status register is at offset 0x3060. A set bit stays set until software clears it.
- R3: A pulse on `cpl_evt` sets status bit 4, which is also sticky.
- R4: Writing 1 to a status bit at 0x3060 clears it. Writing 0 to a status bit leaves it unchanged.
- R5: When an event pulse and a write-1-to-clear hit the same status bit in the same cycle, the bit ends up set.
- R6: The mask register at 0x3070 stores bits [4:0] on a write and reads them back with the same layout as the status register. Bits [31:5] read as zero, and writes to them are ignored.
- R7: `irq_out` is 1 exactly one cycle after any status bit and its mask bit are both 1, and 0 one cycle after no such pair exists.
- R8: The register at 0x3040 reads the live levels of `local_irq` in bits [N_LOCAL-1:0], with zeros above. Writes to it have no effect.
- R9: A read returns `rd_data` with `rd_valid` high on the cycle after the request. Offsets that are not mapped read as zero. `rd_data` is zero while `rd_valid` is low.
- R10: Status bits [31:5] read as zero. Writing ones to them changes no status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 14 | Register byte offset |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data, one cycle after the read |
| rd_valid | output | 1 | Read data valid |
| intx_evt | input | 4 | Legacy interrupt assertion pulses, A to D |
| cpl_evt | input | 1 | Completion-received pulse |
| local_irq | input | N_LOCAL | Live local interrupt levels |
| irq_out | output | 1 | Registered interrupt line |

## Verification
The bench builds the block with N_LOCAL set to 12 rather than the default 16. With that value the zero padding of the live-level register above the input width becomes observable through reads. Events, clears and mask writes are issued so that they collide on one bit in one cycle. This covers both the set-over-clear priority and the one-cycle lag of the interrupt line after a mask or status change.

// File: rtl/rpirq_pkg.sv
package rpirq_pkg;

    localparam int REG_W   = 32;
    localparam int ADDR_W  = 14;
    localparam int N_INTX  = 4;
    localparam int N_EVT   = N_INTX + 1;
    localparam int CPL_BIT = N_INTX;

    localparam logic [ADDR_W-1:0] OFF_STATUS = 14'h3060;
    localparam logic [ADDR_W-1:0] OFF_MASK   = 14'h3070;
    localparam logic [ADDR_W-1:0] OFF_LEVEL  = 14'h3040;

    typedef logic [N_EVT-1:0] evt_vec_t;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_STATUS,
        SEL_MASK,
        SEL_LEVEL
    } reg_sel_e;

    typedef struct packed {
        logic              wr;
        logic              rd;
        reg_sel_e          sel;
        logic [REG_W-1:0]  wdata;
    } reg_req_t;

    function automatic reg_sel_e decode_offset(input logic [ADDR_W-1:0] a);
        reg_sel_e s;
        case (a)
            OFF_STATUS: s = SEL_STATUS;
            OFF_MASK:   s = SEL_MASK;
            OFF_LEVEL:  s = SEL_LEVEL;
            default:    s = SEL_NONE;
        endcase
        return s;
    endfunction

    function automatic evt_vec_t gather_events(input logic [N_INTX-1:0] intx, input logic cpl);
        evt_vec_t v;
        v[N_INTX-1:0] = intx;
        v[CPL_BIT]    = cpl;
        return v;
    endfunction

endpackage

// File: rtl/rpirq_status_bank.sv
module rpirq_status_bank
    import rpirq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  evt_vec_t evt,
    input  logic     clr_en,
    input  evt_vec_t clr_mask,
    output evt_vec_t status
);

    for (genvar i = 0; i < N_EVT; i++) begin : g_bit
        logic bit_q;
        logic clr_hit;

        assign clr_hit = clr_en & clr_mask[i];

        always_ff @(posedge clk) begin
            if (rst) begin
                bit_q <= 1'b0;
            end else if (evt[i]) begin
                bit_q <= 1'b1;
            end else if (clr_hit) begin
                bit_q <= 1'b0;
            end
        end

        assign status[i] = bit_q;

        // R2 / R3 / R5: an event always leaves the bit set, even with a clear
        p_set_wins_r5: assert property (@(posedge clk) disable iff (rst)
            evt[i] |=> status[i]);

        // R4: a clear with no event drops the bit
        p_clear_r4: assert property (@(posedge clk) disable iff (rst)
            (clr_hit && !evt[i]) |=> !status[i]);

        // R2: with neither event nor clear the bit holds
        p_sticky_r2: assert property (@(posedge clk) disable iff (rst)
            (!clr_hit && !evt[i]) |=> $stable(status[i]));
    end

endmodule

// File: rtl/rpirq_mask_reg.sv
module rpirq_mask_reg
    import rpirq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     wr_en,
    input  evt_vec_t wval,
    output evt_vec_t mask
);

    evt_vec_t mask_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
        end else if (wr_en) begin
            mask_q <= wval;
        end
    end

    assign mask = mask_q;

    // R6: a mask write lands on the next cycle
    p_mask_write_r6: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (mask == $past(wval)));

    p_mask_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(mask));

endmodule

// File: rtl/rpirq_readback.sv
module rpirq_readback
    import rpirq_pkg::*;
#(
    parameter int N_LOCAL = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               rd,
    input  reg_sel_e           sel,
    input  evt_vec_t           status,
    input  evt_vec_t           mask,
    input  logic [N_LOCAL-1:0] local_irq,
    output logic [REG_W-1:0]   rd_data,
    output logic               rd_valid
);

    localparam int PAD_LEVEL = REG_W - N_LOCAL;
    localparam int PAD_EVT   = REG_W - N_EVT;

    logic [REG_W-1:0] level_word;
    logic [REG_W-1:0] status_word;
    logic [REG_W-1:0] mask_word;
    logic [REG_W-1:0] mux_word;

    if (PAD_LEVEL > 0) begin : g_pad
        assign level_word = {{PAD_LEVEL{1'b0}}, local_irq};
    end else begin : g_nopad
        assign level_word = local_irq[REG_W-1:0];
    end

    assign status_word = {{PAD_EVT{1'b0}}, status};
    assign mask_word   = {{PAD_EVT{1'b0}}, mask};

    always_comb begin
        unique case (sel)
            SEL_STATUS: mux_word = status_word;
            SEL_MASK:   mux_word = mask_word;
            SEL_LEVEL:  mux_word = level_word;
            default:    mux_word = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd;
            rd_data  <= rd ? mux_word : '0;
        end
    end

    // R9: one-cycle read latency
    p_read_latency_r9: assert property (@(posedge clk) disable iff (rst)
        rd |=> rd_valid);

    p_idle_zero_r9: assert property (@(posedge clk) disable iff (rst)
        !rd |=> (!rd_valid && rd_data == '0));

    // R10 / R6: reserved bits of the event registers read zero
    p_rsvd_zero_r10: assert property (@(posedge clk) disable iff (rst)
        (rd && sel != SEL_LEVEL) |=> (rd_data[REG_W-1:N_EVT] == '0));

endmodule

// File: rtl/rpirq_ctrl.sv
module rpirq_ctrl
    import rpirq_pkg::*;
#(
    parameter int N_LOCAL = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic                reg_wr,
    input  logic                reg_rd,
    input  logic [REG_W-1:0]    reg_wdata,
    output logic [REG_W-1:0]    rd_data,
    output logic                rd_valid,
    input  logic [N_INTX-1:0]   intx_evt,
    input  logic                cpl_evt,
    input  logic [N_LOCAL-1:0]  local_irq,
    output logic                irq_out
);

    reg_req_t req;
    evt_vec_t events;
    evt_vec_t status;
    evt_vec_t mask;
    logic     status_wr;
    logic     mask_wr;
    logic     rsvd_write;
    logic     irq_q;

    always_comb begin
        req.wr    = reg_wr;
        req.rd    = reg_rd;
        req.sel   = decode_offset(reg_addr);
        req.wdata = reg_wdata;
    end

    assign events     = gather_events(intx_evt, cpl_evt);
    assign status_wr  = req.wr && (req.sel == SEL_STATUS);
    assign mask_wr    = req.wr && (req.sel == SEL_MASK);
    assign rsvd_write = req.wr && (|req.wdata[REG_W-1:N_EVT]);

    rpirq_status_bank i_status (
        .clk      (clk),
        .rst      (rst),
        .evt      (events),
        .clr_en   (status_wr),
        .clr_mask (req.wdata[N_EVT-1:0]),
        .status   (status)
    );

    rpirq_mask_reg i_mask (
        .clk  (clk),
        .rst  (rst),
        .wr_en(mask_wr),
        .wval (req.wdata[N_EVT-1:0]),
        .mask (mask)
    );

    rpirq_readback #(.N_LOCAL(N_LOCAL)) i_readback (
        .clk      (clk),
        .rst      (rst),
        .rd       (req.rd),
        .sel      (req.sel),
        .status   (status),
        .mask     (mask),
        .local_irq(local_irq),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= |(status & mask);
        end
    end

    assign irq_out = irq_q;

    // R7: the interrupt line follows the masked status one cycle later
    p_irq_rise_r7: assert property (@(posedge clk) disable iff (rst)
        (|(status & mask)) |=> irq_out);

    p_irq_fall_r7: assert property (@(posedge clk) disable iff (rst)
        !(|(status & mask)) |=> !irq_out);

    // R10: a write with only reserved ones and no event leaves status alone
    p_rsvd_ignored_r10: assert property (@(posedge clk) disable iff (rst)
        (status_wr && rsvd_write && req.wdata[N_EVT-1:0] == '0 && events == '0)
            |=> $stable(status));

endmodule

// File: tb/test_rpirq_ctrl.sv
module test_rpirq_ctrl;

    localparam int NLOC = 12;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [13:0] reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] rd_data;
    logic        rd_valid;
    logic [3:0]  intx_evt = '0;
    logic        cpl_evt = 1'b0;
    logic [NLOC-1:0] local_irq = '0;
    logic        irq_out;

    int n_vec  = 0;
    int n_fail = 0;
    int cycles = 0;
    bit done   = 0;

    // behavioural reference state
    logic [4:0]  m_status = '0;
    logic [4:0]  m_mask   = '0;
    logic        m_irq    = 1'b0;
    logic        m_valid  = 1'b0;
    logic [31:0] m_data   = '0;

    rpirq_ctrl #(.N_LOCAL(NLOC)) i_rpirq_ctrl (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .rd_data(rd_data),
        .rd_valid(rd_valid), .intx_evt(intx_evt), .cpl_evt(cpl_evt),
        .local_irq(local_irq), .irq_out(irq_out)
    );

    always #4 clk = ~clk;

    function automatic logic [31:0] model_read(input logic [13:0] a);
        logic [31:0] v = 32'h0;
        if (a == 14'h3060) v[4:0] = m_status;
        else if (a == 14'h3070) v[4:0] = m_mask;
        else if (a == 14'h3040) v[NLOC-1:0] = local_irq;
        return v;
    endfunction

    always @(posedge clk) begin
        logic [4:0] clr;
        if (rst) begin
            m_status <= '0; m_mask <= '0; m_irq <= 1'b0;
            m_valid <= 1'b0; m_data <= '0;
        end else begin
            clr = (reg_wr && reg_addr == 14'h3060) ? reg_wdata[4:0] : 5'h0;
            m_valid  <= reg_rd;
            m_data   <= reg_rd ? model_read(reg_addr) : 32'h0;
            m_irq    <= |(m_status & m_mask);
            if (reg_wr && reg_addr == 14'h3070) m_mask <= reg_wdata[4:0];
            m_status <= {cpl_evt, intx_evt} | (m_status & ~clr);
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // per-cycle comparison against the reference model
    always @(negedge clk) begin
        if (!rst && !done) begin
            check("R7 irq_out vs model", {31'h0, irq_out}, {31'h0, m_irq});
            check("R9 rd_valid vs model", {31'h0, rd_valid}, {31'h0, m_valid});
            check("R9 rd_data vs model", rd_data, m_data);
        end
    end

    task automatic finish_run();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            n_fail++;
            n_vec++;
            $display("FAIL watchdog actual=%0d expected<20000", cycles);
            finish_run();
        end
    end

    task automatic do_write(input logic [13:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic do_read(input logic [13:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0;
        check({tag, " rd_valid"}, {31'h0, rd_valid}, 32'h1);
        check(tag, rd_data, exp);
    endtask

    task automatic pulse(input logic [3:0] ix, input logic c);
        @(negedge clk);
        intx_evt = ix; cpl_evt = c;
        @(negedge clk);
        intx_evt = '0; cpl_evt = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 irq_out in reset", {31'h0, irq_out}, 32'h0);
        check("R1 rd_valid in reset", {31'h0, rd_valid}, 32'h0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 rd_data after reset", rd_data, 32'h0);
        do_read(14'h3060, 32'h0, "R1 status after reset");
        do_read(14'h3070, 32'h0, "R1 mask after reset");

        pulse(4'b0001, 1'b0);
        do_read(14'h3060, 32'h01, "R2 INTA sets bit0");
        pulse(4'b1010, 1'b0);
        do_read(14'h3060, 32'h0B, "R2 INTB/INTD sticky");
        pulse(4'b0000, 1'b1);
        do_read(14'h3060, 32'h1B, "R3 completion sets bit4");

        do_write(14'h3060, 32'h03);
        do_read(14'h3060, 32'h18, "R4 write-1 clears");
        do_write(14'h3060, 32'h00);
        do_read(14'h3060, 32'h18, "R4 write-0 keeps");

        // set and clear on bit4 in the same cycle
        @(negedge clk);
        reg_addr = 14'h3060; reg_wdata = 32'h10; reg_wr = 1'b1; cpl_evt = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0; cpl_evt = 1'b0;
        do_read(14'h3060, 32'h18, "R5 set wins over clear");

        do_write(14'h3060, 32'hFFFF_FFE0);
        do_read(14'h3060, 32'h18, "R10 reserved writes ignored");

        do_write(14'h3070, 32'hFFFF_FFFF);
        do_read(14'h3070, 32'h1F, "R6 mask reserved reads zero");
        do_write(14'h3070, 32'h0);
        do_read(14'h3070, 32'h0, "R6 mask cleared");

        check("R7 no enabled bit, line low", {31'h0, irq_out}, 32'h0);
        @(negedge clk);
        reg_addr = 14'h3070; reg_wdata = 32'h08; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
        check("R7 line still low one cycle after mask write", {31'h0, irq_out}, 32'h0);
        @(negedge clk);
        check("R7 line high after lag", {31'h0, irq_out}, 32'h1);
        @(negedge clk);
        reg_addr = 14'h3060; reg_wdata = 32'h08; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
        check("R7 line holds one cycle after clear", {31'h0, irq_out}, 32'h1);
        @(negedge clk);
        check("R7 line drops after clear", {31'h0, irq_out}, 32'h0);
        pulse(4'b0000, 1'b1);
        do_write(14'h3070, 32'h10);
        @(negedge clk);
        check("R7 completion enabled drives line", {31'h0, irq_out}, 32'h1);

        local_irq = 12'hA5C;
        do_read(14'h3040, 32'h0000_0A5C, "R8 live levels zero-extended");
        do_write(14'h3040, 32'hFFFF_FFFF);
        do_read(14'h3040, 32'h0000_0A5C, "R8 write ignored");
        local_irq = 12'h3F1;
        do_read(14'h3040, 32'h0000_03F1, "R8 follows inputs");

        do_read(14'h3050, 32'h0, "R9 unmapped reads zero");
        @(negedge clk);
        check("R9 idle rd_data zero", rd_data, 32'h0);

        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule